// File: doc/BRIEF.md
# Row-Slotted Buffer Memory Arbiter

This block places every access to one single-port buffer memory into a fixed time-division schedule. A free-running slot counter divides time into row periods of eight clock cycles, and each cycle of a period belongs to exactly one kind of access. The period opens with a configuration read slot and a configuration write slot, which serve slow-control traffic while data taking continues. A raw-data write slot and a raw-data read slot come next. The last four slots are a read and a write of the active pedestal bank, then a read and a write of the inactive bank. The memory holds 1024 words of 144 bits: 128 pixel bits, which are sixteen 8-bit pixels, and 16 protection bits that are carried through unchanged. Data words are addressed by the current row. The upper half of the memory holds two pedestal banks. One bank is used for correction while the other can be rewritten, and software can ask for the two to be swapped.

The data, pedestal and configuration clients present per-slot enables or level requests. When a slot's cycle arrives, the arbiter registers one memory request. The read result comes back two cycles after the slot cycle, tagged with the slot number. A pedestal read also returns one mask bit per pixel, which flags every pixel whose pedestal byte is 255. Configuration accesses use an address pointer that can be loaded and that advances by one after each access. A bank-swap request never takes effect in the middle of a row. A behavioural memory stands in for the SRAM and its error-correction logic.

Top module: `row_slot_arbiter`

## Requirements
- R1: After reset `phase` and `row` are 0. `phase` counts 0,1,...,7,0 one step per cycle, and `row` increments, wrapping at 255, in the cycle after `phase` was 7.
- R2: The slot order is fixed: phase 0 is the configuration read, 1 the configuration write, 2 the raw write, 3 the raw read, 4 the active-bank pedestal read, 5 the active-bank pedestal write, 6 the inactive-bank pedestal read and 7 the inactive-bank pedestal write. An access granted in phase k appears on `mem_en`/`mem_we`/`mem_addr` in the following cycle.
- R3: Address map. Raw slots use address `row` (words 0-255). Pedestal bank A is words 512+row and bank B is words 768+row. `act_bank`=0 selects A as the active bank, and the inactive bank is always the other one. Configuration slots use `cfg_ptr`, so they can reach any word, including 256-511.
- R4: A slot whose enable (or configuration request) is low in its cycle produces no memory access: `mem_en` stays low in the following cycle.
- R5: `cfg_rd_ack` is high only in phase 0 while `cfg_rd_req` is high, and `cfg_wr_ack` only in phase 1 while `cfg_wr_req` is high. A request raised in any other phase waits for its slot.
- R6: `cfg_addr_ld` loads `cfg_ptr` from `cfg_addr_val` and has priority over advancing. Each acknowledged configuration access advances `cfg_ptr` by one, wrapping 1023 to 0.
- R7: A read issued in a slot cycle gives `rd_valid` two cycles later, with `rd_slot` equal to the slot number and `rd_data` equal to the last word written to that address. Writes produce no `rd_valid`. A raw write followed by the raw read of the same row returns the new word.
- R8: `rd_mask[i]` is 1 exactly when bits [8i+7:8i] of `rd_data` equal 8'hFF and the result comes from slot 4 or 6. For every other slot `rd_mask` is 0.
- R9: `act_bank` is 0 after reset. A `swap_req` pulse toggles it at the next row start, that is, in the cycle where `phase` becomes 0. Any number of pulses within one row gives a single toggle, and `act_bank` never changes in any other phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_req | input | 1 | Pulse: swap active and inactive pedestal banks at next row start |
| raw_wr_en | input | 1 | Raw-data write enable, sampled in phase 2 |
| raw_rd_en | input | 1 | Raw-data read enable, sampled in phase 3 |
| pa_rd_en | input | 1 | Active-bank pedestal read enable, phase 4 |
| pa_wr_en | input | 1 | Active-bank pedestal write enable, phase 5 |
| pi_rd_en | input | 1 | Inactive-bank pedestal read enable, phase 6 |
| pi_wr_en | input | 1 | Inactive-bank pedestal write enable, phase 7 |
| wr_data | input | 144 | Write word for the raw and pedestal write slots |
| cfg_addr_ld | input | 1 | Load the configuration pointer |
| cfg_addr_val | input | 10 | Value loaded into the configuration pointer |
| cfg_rd_req | input | 1 | Configuration read request, held until acknowledged |
| cfg_wr_req | input | 1 | Configuration write request, held until acknowledged |
| cfg_wdata | input | 144 | Configuration write word |
| cfg_rd_ack | output | 1 | Configuration read granted this cycle |
| cfg_wr_ack | output | 1 | Configuration write granted this cycle |
| cfg_ptr | output | 10 | Current configuration address |
| phase | output | 3 | Current slot within the row period |
| row | output | 8 | Current row |
| act_bank | output | 1 | Active pedestal bank: 0 = A (512-767), 1 = B (768-1023) |
| mem_en | output | 1 | Memory access issued this cycle |
| mem_we | output | 1 | Issued access is a write |
| mem_addr | output | 10 | Issued access address |
| rd_valid | output | 1 | Read result valid |
| rd_slot | output | 3 | Slot that issued the returned read |
| rd_data | output | 144 | Returned word |
| rd_mask | output | 16 | Per-pixel mask for pedestal reads |

## Verification
The bench writes a raw word and reads it back in the same row. A design that ordered the slots differently, or that read before the write had landed, would return a stale word. Pedestals are loaded through the configuration pointer into both banks. They are then read through slots 4 and 6, with bytes of 0xFF placed so that a mask computed with the wrong polarity or on the wrong slot would show. An all-ones raw word must return an empty mask. Swap pulses are sent twice within one row and once in the last phase. A design that toggled immediately, toggled twice, or dropped a request from phase 7 would show the wrong `act_bank`, or write pedestals to the wrong half. Configuration requests raised mid-row, a pointer wrap at 1023, and an access to the second data region test the grant timing and the pointer arithmetic.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  // Slot numbering is behaviour: the order defines the row schedule.
  typedef enum logic [2:0] {
    SL_CFG_RD = 3'd0,
    SL_CFG_WR = 3'd1,
    SL_DAT_WR = 3'd2,
    SL_DAT_RD = 3'd3,
    SL_PA_RD  = 3'd4,
    SL_PA_WR  = 3'd5,
    SL_PI_RD  = 3'd6,
    SL_PI_WR  = 3'd7
  } slot_e;

  localparam int unsigned SLOTS_PER_ROW = 8;
endpackage

// File: rtl/rsa_slot_timer.sv
module rsa_slot_timer
  import rsa_pkg::*;
#(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             swap_req,
  output logic [2:0]       phase,
  output logic [ROW_W-1:0] row,
  output logic             act_bank
);
  logic swap_pend;
  logic last_slot;

  assign last_slot = (phase == 3'(SLOTS_PER_ROW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      row       <= '0;
      act_bank  <= 1'b0;
      swap_pend <= 1'b0;
    end else begin
      phase <= phase + 3'd1;
      if (last_slot) begin
        row <= row + 1'b1;
      end
      // R9: bank flips only when a new row period begins
      if (last_slot && (swap_pend || swap_req)) begin
        act_bank  <= ~act_bank;
        swap_pend <= 1'b0;
      end else if (swap_req) begin
        swap_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsa_cfg_port.sv
module rsa_cfg_port
  import rsa_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        phase,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              rd_req,
  input  logic              wr_req,
  output logic              rd_ack,
  output logic              wr_ack,
  output logic [ADDR_W-1:0] ptr
);
  assign rd_ack = rd_req && (phase == SL_CFG_RD);
  assign wr_ack = wr_req && (phase == SL_CFG_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (ld) begin
      ptr <= ld_val;
    end else if (rd_ack || wr_ack) begin
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/rsa_issue.sv
module rsa_issue
  import rsa_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int WORD_W = 144,
  localparam int ADDR_W = ROW_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        phase,
  input  logic [ROW_W-1:0]  row,
  input  logic              act_bank,
  input  logic [ADDR_W-1:0] cfg_ptr,
  input  logic              cfg_rd_ack,
  input  logic              cfg_wr_ack,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              raw_wr_en,
  input  logic              raw_rd_en,
  input  logic              pa_rd_en,
  input  logic              pa_wr_en,
  input  logic              pi_rd_en,
  input  logic              pi_wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [2:0]        mem_slot
);
  logic              n_en;
  logic              n_we;
  logic [ADDR_W-1:0] n_addr;
  logic [WORD_W-1:0] n_wd;
  logic [ADDR_W-1:0] dat_addr;
  logic [ADDR_W-1:0] act_addr;
  logic [ADDR_W-1:0] ina_addr;

  assign dat_addr = {2'b00, row};
  assign act_addr = {1'b1, act_bank, row};
  assign ina_addr = {1'b1, ~act_bank, row};

  always_comb begin
    n_en   = 1'b0;
    n_we   = 1'b0;
    n_addr = dat_addr;
    n_wd   = wr_data;
    case (slot_e'(phase))
      SL_CFG_RD: begin n_en = cfg_rd_ack; n_addr = cfg_ptr; end
      SL_CFG_WR: begin n_en = cfg_wr_ack; n_we = 1'b1; n_addr = cfg_ptr; n_wd = cfg_wdata; end
      SL_DAT_WR: begin n_en = raw_wr_en;  n_we = 1'b1; end
      SL_DAT_RD: begin n_en = raw_rd_en; end
      SL_PA_RD:  begin n_en = pa_rd_en;   n_addr = act_addr; end
      SL_PA_WR:  begin n_en = pa_wr_en;   n_we = 1'b1; n_addr = act_addr; end
      SL_PI_RD:  begin n_en = pi_rd_en;   n_addr = ina_addr; end
      SL_PI_WR:  begin n_en = pi_wr_en;   n_we = 1'b1; n_addr = ina_addr; end
      default:   begin n_en = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en   <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_slot <= '0;
    end else begin
      mem_en   <= n_en;
      mem_we   <= n_we;
      mem_addr <= n_addr;
      mem_slot <= phase;
    end
  end

  always_ff @(posedge clk) begin
    mem_wdata <= n_wd;
  end
endmodule

// File: rtl/rsa_mem.sv
module rsa_mem
  import rsa_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PIX_W  = 8,
  parameter int PIX_N  = 16,
  parameter int PAR_W  = 16,
  localparam int DATA_W = PIX_W * PIX_N,
  localparam int WORD_W = DATA_W + PAR_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [2:0]        slot,
  output logic              rd_valid,
  output logic [2:0]        rd_slot,
  output logic [WORD_W-1:0] rd_data,
  output logic [PIX_N-1:0]  rd_mask
);
  logic [WORD_W-1:0] store [DEPTH];
  logic [PIX_N-1:0]  full_pix;
  logic              ped_rd;

  // single-port array, write-first not needed: one access per cycle
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        store[addr] <= wdata;
      end else begin
        rd_data <= store[addr];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_slot  <= '0;
    end else begin
      rd_valid <= en && !we;
      rd_slot  <= slot;
    end
  end

  for (genvar g = 0; g < PIX_N; g++) begin : g_pix
    assign full_pix[g] = &rd_data[g*PIX_W +: PIX_W];
  end

  assign ped_rd  = (rd_slot == SL_PA_RD) || (rd_slot == SL_PI_RD);
  assign rd_mask = ped_rd ? full_pix : '0;
endmodule

// File: rtl/row_slot_arbiter.sv
module row_slot_arbiter
  import rsa_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int PIX_W = 8,
  parameter int PIX_N = 16,
  parameter int PAR_W = 16,
  localparam int ADDR_W = ROW_W + 2,
  localparam int WORD_W = PIX_W * PIX_N + PAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              swap_req,
  input  logic              raw_wr_en,
  input  logic              raw_rd_en,
  input  logic              pa_rd_en,
  input  logic              pa_wr_en,
  input  logic              pi_rd_en,
  input  logic              pi_wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              cfg_addr_ld,
  input  logic [ADDR_W-1:0] cfg_addr_val,
  input  logic              cfg_rd_req,
  input  logic              cfg_wr_req,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic              cfg_rd_ack,
  output logic              cfg_wr_ack,
  output logic [ADDR_W-1:0] cfg_ptr,
  output logic [2:0]        phase,
  output logic [ROW_W-1:0]  row,
  output logic              act_bank,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rd_valid,
  output logic [2:0]        rd_slot,
  output logic [WORD_W-1:0] rd_data,
  output logic [PIX_N-1:0]  rd_mask
);
  logic [WORD_W-1:0] mem_wdata;
  logic [2:0]        mem_slot;

  rsa_slot_timer #(.ROW_W(ROW_W)) u_timer (
    .clk(clk), .rst(rst), .swap_req(swap_req),
    .phase(phase), .row(row), .act_bank(act_bank)
  );

  rsa_cfg_port #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .phase(phase),
    .ld(cfg_addr_ld), .ld_val(cfg_addr_val),
    .rd_req(cfg_rd_req), .wr_req(cfg_wr_req),
    .rd_ack(cfg_rd_ack), .wr_ack(cfg_wr_ack), .ptr(cfg_ptr)
  );

  rsa_issue #(.ROW_W(ROW_W), .WORD_W(WORD_W)) u_issue (
    .clk(clk), .rst(rst), .phase(phase), .row(row), .act_bank(act_bank),
    .cfg_ptr(cfg_ptr), .cfg_rd_ack(cfg_rd_ack), .cfg_wr_ack(cfg_wr_ack),
    .cfg_wdata(cfg_wdata),
    .raw_wr_en(raw_wr_en), .raw_rd_en(raw_rd_en),
    .pa_rd_en(pa_rd_en), .pa_wr_en(pa_wr_en),
    .pi_rd_en(pi_rd_en), .pi_wr_en(pi_wr_en),
    .wr_data(wr_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_slot(mem_slot)
  );

  rsa_mem #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .PIX_N(PIX_N), .PAR_W(PAR_W)) u_mem (
    .clk(clk), .rst(rst), .en(mem_en), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .slot(mem_slot),
    .rd_valid(rd_valid), .rd_slot(rd_slot), .rd_data(rd_data), .rd_mask(rd_mask)
  );
endmodule

// File: rtl/rsa_checker.sv
module rsa_checker #(
  parameter int ROW_W  = 8,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        phase,
  input logic [ROW_W-1:0]  row,
  input logic              act_bank,
  input logic              raw_wr_en,
  input logic              raw_rd_en,
  input logic              cfg_addr_ld,
  input logic              cfg_rd_ack,
  input logic              cfg_wr_ack,
  input logic [ADDR_W-1:0] cfg_ptr,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rd_valid,
  input logic [2:0]        rd_slot,
  input logic [15:0]       rd_mask
);
  logic [2:0]        ph_inc;
  logic [ROW_W-1:0]  row_inc;
  logic [ADDR_W-1:0] ptr_inc;

  assign ph_inc  = phase + 3'd1;
  assign row_inc = row + 1'b1;
  assign ptr_inc = cfg_ptr + 1'b1;

  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd7) |=> (phase == 3'd0) && (row == $past(row_inc)));

  p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
    (phase != 3'd7) |=> (phase == $past(ph_inc)) && $stable(row));

  p_raw_region_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd2) && raw_wr_en |=> mem_en && mem_we && (mem_addr[ADDR_W-1 -: 2] == 2'b00));

  p_idle_slot_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd3) && !raw_rd_en |=> !mem_en);

  p_cfg_rd_issue_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_rd_ack |=> mem_en && !mem_we && (mem_addr == $past(cfg_ptr)));

  p_cfg_wr_issue_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_ack |=> mem_en && mem_we && (mem_addr == $past(cfg_ptr)));

  p_ptr_advance_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_ack || cfg_wr_ack) && !cfg_addr_ld |=> (cfg_ptr == $past(ptr_inc)));

  p_read_returns_r7: assert property (@(posedge clk) disable iff (rst)
    mem_en && !mem_we |=> rd_valid);

  p_write_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (!mem_en || mem_we) |=> !rd_valid);

  p_mask_ped_only_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid && (rd_slot != 3'd4) && (rd_slot != 3'd6) |-> (rd_mask == 16'd0));

  p_bank_at_row_start_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_bank) |-> (phase == 3'd0));
endmodule

bind row_slot_arbiter rsa_checker #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .row(row), .act_bank(act_bank),
  .raw_wr_en(raw_wr_en), .raw_rd_en(raw_rd_en), .cfg_addr_ld(cfg_addr_ld),
  .cfg_rd_ack(cfg_rd_ack), .cfg_wr_ack(cfg_wr_ack), .cfg_ptr(cfg_ptr),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
  .rd_valid(rd_valid), .rd_slot(rd_slot), .rd_mask(rd_mask)
);

// File: tb/row_slot_arbiter_test.sv
module row_slot_arbiter_test;
  localparam int W = 144;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          swap_req = 1'b0;
  logic          raw_wr_en = 1'b0, raw_rd_en = 1'b0;
  logic          pa_rd_en = 1'b0, pa_wr_en = 1'b0, pi_rd_en = 1'b0, pi_wr_en = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic          cfg_addr_ld = 1'b0;
  logic [9:0]    cfg_addr_val = '0;
  logic          cfg_rd_req = 1'b0, cfg_wr_req = 1'b0;
  logic [W-1:0]  cfg_wdata = '0;
  logic          cfg_rd_ack, cfg_wr_ack;
  logic [9:0]    cfg_ptr;
  logic [2:0]    phase;
  logic [7:0]    row;
  logic          act_bank;
  logic          mem_en, mem_we;
  logic [9:0]    mem_addr;
  logic          rd_valid;
  logic [2:0]    rd_slot;
  logic [W-1:0]  rd_data;
  logic [15:0]   rd_mask;

  always #2 clk = ~clk;

  row_slot_arbiter uut (
    .clk(clk), .rst(rst), .swap_req(swap_req),
    .raw_wr_en(raw_wr_en), .raw_rd_en(raw_rd_en),
    .pa_rd_en(pa_rd_en), .pa_wr_en(pa_wr_en), .pi_rd_en(pi_rd_en), .pi_wr_en(pi_wr_en),
    .wr_data(wr_data), .cfg_addr_ld(cfg_addr_ld), .cfg_addr_val(cfg_addr_val),
    .cfg_rd_req(cfg_rd_req), .cfg_wr_req(cfg_wr_req), .cfg_wdata(cfg_wdata),
    .cfg_rd_ack(cfg_rd_ack), .cfg_wr_ack(cfg_wr_ack), .cfg_ptr(cfg_ptr),
    .phase(phase), .row(row), .act_bank(act_bank),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .rd_valid(rd_valid), .rd_slot(rd_slot), .rd_data(rd_data), .rd_mask(rd_mask)
  );

  typedef struct packed {
    logic [2:0]   s;
    logic [W-1:0] d;
    logic [15:0]  m;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  logic bank_m  = 1'b0;

  task automatic chk(input bit ok, input string req, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic logic [15:0] ped_mask(input logic [W-1:0] d);
    logic [15:0] m;
    for (int i = 0; i < 16; i++) m[i] = (d[8*i +: 8] == 8'hFF);
    return m;
  endfunction

  // scoreboard monitor: every read return is matched against the queue
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7", $sformatf("unexpected return slot %0d", rd_slot));
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(rd_slot == e.s, "R7", $sformatf("slot act %0d exp %0d", rd_slot, e.s));
        chk(rd_data == e.d, "R7", $sformatf("data act %0h exp %0h", rd_data, e.d));
        chk(rd_mask == e.m, "R8", $sformatf("mask act %0h exp %0h", rd_mask, e.m));
      end
    end
  end

  task automatic wait_phase(input int k);
    while (phase != 3'(k)) @(negedge clk);
  endtask

  // one slot access; entered and left at a falling edge
  task automatic slot_go(input int k, input logic [W-1:0] d, input logic [W-1:0] exp_rd);
    logic [9:0] ea;
    wait_phase(k);
    case (k)
      2, 3:    ea = {2'b00, row};
      4, 5:    ea = {1'b1, bank_m, row};
      default: ea = {1'b1, ~bank_m, row};
    endcase
    wr_data = d;
    case (k)
      2: raw_wr_en = 1'b1;
      3: raw_rd_en = 1'b1;
      4: pa_rd_en  = 1'b1;
      5: pa_wr_en  = 1'b1;
      6: pi_rd_en  = 1'b1;
      default: pi_wr_en = 1'b1;
    endcase
    if (k == 3) q.push_back('{3'(k), exp_rd, 16'd0});
    if (k == 4 || k == 6) q.push_back('{3'(k), exp_rd, ped_mask(exp_rd)});
    @(negedge clk);
    {raw_wr_en, raw_rd_en, pa_rd_en, pa_wr_en, pi_rd_en, pi_wr_en} = '0;
    chk(mem_en && (mem_we == (k == 2 || k == 5 || k == 7)), "R2",
        $sformatf("slot %0d en/we act %0b%0b", k, mem_en, mem_we));
    chk(mem_addr == ea, "R3", $sformatf("slot %0d addr act %0d exp %0d", k, mem_addr, ea));
  endtask

  task automatic load_ptr(input logic [9:0] a);
    cfg_addr_ld = 1'b1; cfg_addr_val = a;
    @(negedge clk);
    cfg_addr_ld = 1'b0;
    chk(cfg_ptr == a, "R6", $sformatf("load act %0d exp %0d", cfg_ptr, a));
  endtask

  task automatic cfg_op(input bit wr, input logic [W-1:0] d);
    logic [2:0] ph;
    logic [9:0] p0;
    if (wr) begin cfg_wr_req = 1'b1; cfg_wdata = d; end
    else cfg_rd_req = 1'b1;
    #1;
    while (!(wr ? cfg_wr_ack : cfg_rd_ack)) begin @(negedge clk); #1; end
    ph = phase;
    p0 = cfg_ptr;
    if (!wr) q.push_back('{3'd0, d, 16'd0});
    @(negedge clk);
    cfg_wr_req = 1'b0; cfg_rd_req = 1'b0;
    chk(ph == (wr ? 3'd1 : 3'd0), "R5", $sformatf("ack phase act %0d", ph));
    chk(mem_en && (mem_we == wr) && (mem_addr == p0), "R2",
        $sformatf("cfg issue en %0b we %0b addr %0d exp %0d", mem_en, mem_we, mem_addr, p0));
    chk(cfg_ptr == 10'(p0 + 10'd1), "R6", $sformatf("ptr act %0d exp %0d", cfg_ptr, 10'(p0 + 10'd1)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]   r0, tgt;
    logic [W-1:0] d1, pa, pb;
    bit           idle_ok;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 and R9 reset state
    chk(phase == 0 && row == 0, "R1", $sformatf("reset phase %0d row %0d exp 0 0", phase, row));
    chk(act_bank == 1'b0 && !mem_en && !rd_valid && cfg_ptr == 0, "R9",
        $sformatf("reset bank %0b en %0b valid %0b", act_bank, mem_en, rd_valid));

    // R4: no enables for a whole row -> no access
    idle_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (mem_en) idle_ok = 1'b0; end
    chk(idle_ok, "R4", "mem_en seen high with no requests, exp low");

    // R1: row advances after phase 7
    wait_phase(7);
    r0 = row;
    @(negedge clk);
    chk(phase == 0 && row == 8'(r0 + 1), "R1", $sformatf("row act %0d exp %0d", row, 8'(r0 + 1)));

    // R7: raw write then raw read in the same row
    d1 = {16'h5A5A, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210};
    r0 = row;
    slot_go(2, d1, '0);
    slot_go(3, '0, d1);
    // R8: all-ones raw word returns an empty mask
    slot_go(2, {W{1'b1}}, '0);
    slot_go(3, '0, {W{1'b1}});
    // R3: the first raw word is visible through the configuration port at address row
    load_ptr({2'b00, r0});
    cfg_op(1'b0, d1);

    // R3 R8: load both pedestal banks for a future row and read through slots 4 and 6
    tgt = 8'(row + 4);
    pa = {16'h00C3, 128'h00FF_1234_FFFF_0000_FE01_FF10_2030_40FF};
    pb = {16'hFFFF, {128{1'b1}}};
    load_ptr({2'b10, tgt});
    cfg_op(1'b1, pa);
    load_ptr({2'b11, tgt});
    cfg_op(1'b1, pb);
    while (!(row == tgt && phase == 3'd4)) @(negedge clk);
    slot_go(4, '0, pa);
    slot_go(6, '0, pb);

    // R9: two swap pulses in one row give one toggle at the row start
    wait_phase(2);
    swap_req = 1'b1; @(negedge clk); swap_req = 1'b0;
    swap_req = 1'b1; @(negedge clk); swap_req = 1'b0;
    wait_phase(7);
    chk(act_bank == 1'b0, "R9", $sformatf("mid-row bank act %0b exp 0", act_bank));
    @(negedge clk);
    chk(act_bank == 1'b1, "R9", $sformatf("row start bank act %0b exp 1", act_bank));
    bank_m = 1'b1;
    // R3: with bank B active, pedestal writes land in the swapped halves
    slot_go(5, pa, '0);
    slot_go(7, pb, '0);
    // R9: request in phase 7 flips at the very next row start
    wait_phase(7);
    swap_req = 1'b1; @(negedge clk); swap_req = 1'b0;
    chk(act_bank == 1'b0, "R9", $sformatf("phase-7 swap bank act %0b exp 0", act_bank));
    bank_m = 1'b0;

    // R6: pointer wraps from 1023 to 0
    load_ptr(10'd1023);
    cfg_op(1'b1, d1);
    load_ptr(10'd1023);
    cfg_op(1'b0, d1);
    // R3: second data region reached only through configuration
    load_ptr(10'd300);
    cfg_op(1'b1, pa);
    load_ptr(10'd300);
    cfg_op(1'b0, pa);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R7", $sformatf("pending returns act %0d exp 0", q.size()));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule